// File: doc/BRIEF.md
# Four-Fold Coincidence Unit with Veto

This block forms a trigger decision from four single-bit hit pulses that arrive synchronous to the clock. A static mode bit selects the combining function. In AND mode the trigger needs every enabled input to be hit in the same cycle. In OR mode any enabled input is enough. Each input has its own enable bit. Inputs that are switched off play no part in the decision. A bank of veto inputs, each with its own enable switch, blocks the decision in any cycle where an enabled veto is high.

A qualified decision starts a stretched pulse. Its width is programmable from 1 to 15 clock cycles, and a new trigger cannot start until the current pulse has ended. The pulse drives several output copies, and each copy has its own inversion bit. The hit and veto pins are plain level pins sampled every cycle, with no handshake, because a discriminator cannot hold back its hits. All configuration pins are plain static bits.

Top module: `coinc_unit`

## Requirements
- R1: After reset, with no trigger pending, each output `trig_o[i]` sits at its idle level, which is `out_inv_i[i]`.
- R2: AND mode (`mode_or_i`=0): a trigger is formed when every input whose enable bit is 1 is hit in the same cycle. A disabled input counts as hit.
- R3: OR mode (`mode_or_i`=1): a trigger is formed when at least one enabled input is hit. A disabled input counts as not hit.
- R4: With `in_en_i` all zero, no trigger is formed in either mode.
- R5: In a cycle where any veto bit `veto_i[j]` is 1 and its switch `veto_en_i[j]` is also 1, no trigger is formed. A veto whose switch is 0 has no effect.
- R6: The output pulse lasts exactly `width_i` cycles for values 1 to 15. A `width_i` of 0 is treated as 1.
- R7: There is no retrigger. While a pulse is active, further triggers are ignored. When triggers keep coming, pulses of the programmed width repeat, separated by one idle cycle.
- R8: Inversion is applied after stretching. An output with `out_inv_i[i]`=1 idles high and goes low for the duration of the pulse.
- R9: Timing: hits and vetoes sampled at clock edge E0 produce the active output level right after edge E1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hit_i | input | 4 | Discriminator hit pulses |
| in_en_i | input | 4 | Per-input enable |
| mode_or_i | input | 1 | 1 = OR, 0 = AND |
| veto_i | input | 2 | Veto levels |
| veto_en_i | input | 2 | Per-veto enable switch |
| width_i | input | 4 | Output pulse width in cycles (0 treated as 1) |
| out_inv_i | input | 3 | Per-output inversion |
| trig_o | output | 3 | Trigger output copies |

## Verification
A decision takes one register stage and the stretch counter takes a second, so the output for hits sampled at edge E0 first shows after edge E1. The bench drives inputs on a falling edge and clears the hits at the next falling edge. It then samples on the falling edge that follows E1. Width checks count the high samples over a window longer than any pulse. The retrigger check holds the hits steady and compares one sample per cycle against the expected sequence of W high cycles followed by one low cycle.

// File: rtl/coinc_pkg.sv
package coinc_pkg;
  localparam int N_HIT  = 4;
  localparam int N_VETO = 2;
  localparam int N_OUT  = 3;
  localparam int WID_W  = 4;
  typedef enum logic {CMB_AND = 1'b0, CMB_OR = 1'b1} cmb_mode_e;
endpackage

// File: rtl/coinc_decide.sv
module coinc_decide #(
  parameter int N_HIT  = coinc_pkg::N_HIT,
  parameter int N_VETO = coinc_pkg::N_VETO
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_HIT-1:0]  hit,
  input  logic [N_HIT-1:0]  en,
  input  logic              mode_or,
  input  logic [N_VETO-1:0] veto,
  input  logic [N_VETO-1:0] veto_en,
  output logic              fire_q
);
  import coinc_pkg::*;
  logic all_ok, any_ok, blocked, raw;
  cmb_mode_e mode;

  always_comb begin
    mode    = cmb_mode_e'(mode_or);
    all_ok  = &(hit | ~en);
    any_ok  = |(hit & en);
    blocked = |(veto & veto_en);
    raw     = 1'b0;
    if (|en) raw = (mode == CMB_OR) ? any_ok : all_ok;
    if (blocked) raw = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) fire_q <= 1'b0;
    else        fire_q <= raw;
endmodule

// File: rtl/coinc_stretch.sv
module coinc_stretch #(
  parameter int WID_W = coinc_pkg::WID_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic [WID_W-1:0] width,
  output logic             active
);
  logic [WID_W-1:0] cnt, w_eff;

  always_comb w_eff = (width == '0) ? WID_W'(1) : width;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                  cnt <= '0;
    else if (cnt != '0)          cnt <= cnt - 1'b1;
    else if (fire)               cnt <= w_eff;

  assign active = (cnt != '0);
endmodule

// File: rtl/coinc_outdrv.sv
module coinc_outdrv #(
  parameter int N_OUT = coinc_pkg::N_OUT
) (
  input  logic             active,
  input  logic [N_OUT-1:0] inv,
  output logic [N_OUT-1:0] q
);
  for (genvar i = 0; i < N_OUT; i++) begin : g_copy
    assign q[i] = active ^ inv[i];
  end
endmodule

// File: rtl/coinc_unit.sv
module coinc_unit #(
  parameter int N_HIT  = coinc_pkg::N_HIT,
  parameter int N_VETO = coinc_pkg::N_VETO,
  parameter int N_OUT  = coinc_pkg::N_OUT,
  parameter int WID_W  = coinc_pkg::WID_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_HIT-1:0]  hit_i,
  input  logic [N_HIT-1:0]  in_en_i,
  input  logic              mode_or_i,
  input  logic [N_VETO-1:0] veto_i,
  input  logic [N_VETO-1:0] veto_en_i,
  input  logic [WID_W-1:0]  width_i,
  input  logic [N_OUT-1:0]  out_inv_i,
  output logic [N_OUT-1:0]  trig_o
);
  logic fire_q, active;

  coinc_decide #(.N_HIT(N_HIT), .N_VETO(N_VETO)) u_decide (
    .clk(clk), .rst_n(rst_n), .hit(hit_i), .en(in_en_i), .mode_or(mode_or_i),
    .veto(veto_i), .veto_en(veto_en_i), .fire_q(fire_q));

  coinc_stretch #(.WID_W(WID_W)) u_stretch (
    .clk(clk), .rst_n(rst_n), .fire(fire_q), .width(width_i), .active(active));

  coinc_outdrv #(.N_OUT(N_OUT)) u_out (
    .active(active), .inv(out_inv_i), .q(trig_o));
endmodule

// File: rtl/coinc_unit_chk.sv
module coinc_unit_chk #(
  parameter int N_HIT  = 4,
  parameter int N_VETO = 2,
  parameter int N_OUT  = 3,
  parameter int WID_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_HIT-1:0]  hit_i,
  input logic [N_HIT-1:0]  in_en_i,
  input logic              mode_or_i,
  input logic [N_VETO-1:0] veto_i,
  input logic [N_VETO-1:0] veto_en_i,
  input logic [N_OUT-1:0]  out_inv_i,
  input logic [N_OUT-1:0]  trig_o,
  input logic              fire_q,
  input logic              active
);
  logic [WID_W:0] run_len;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      run_len <= '0;
    else if (active) run_len <= run_len + 1'b1;
    else             run_len <= '0;

  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> trig_o == out_inv_i);                                   // R1
  AST_AND_NEEDS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_or_i && !(&(hit_i | ~in_en_i))) |=> !fire_q);                // R2
  AST_OR_NEEDS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_or_i && (hit_i & in_en_i) == '0) |=> !fire_q);                // R3
  AST_NO_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_en_i == '0) |=> !fire_q);                                       // R4
  AST_VETO_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    ((veto_i & veto_en_i) != '0) |=> !fire_q);                          // R5
  AST_WIDTH_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    run_len <= (WID_W+1)'((1 << WID_W) - 1));                           // R6
  AST_START_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> $past(fire_q));                                   // R9
endmodule

bind coinc_unit coinc_unit_chk #(.N_HIT(N_HIT), .N_VETO(N_VETO), .N_OUT(N_OUT), .WID_W(WID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .hit_i(hit_i), .in_en_i(in_en_i), .mode_or_i(mode_or_i),
  .veto_i(veto_i), .veto_en_i(veto_en_i), .out_inv_i(out_inv_i), .trig_o(trig_o),
  .fire_q(fire_q), .active(active));

// File: tb/sim_coinc_unit.sv
module sim_coinc_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] hit_i = '0, in_en_i = '0, width_i = 4'd1;
  logic       mode_or_i = 1'b0;
  logic [1:0] veto_i = '0, veto_en_i = '0;
  logic [2:0] out_inv_i = '0;
  logic [2:0] trig_o;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  coinc_unit u0 (.clk(clk), .rst_n(rst_n), .hit_i(hit_i), .in_en_i(in_en_i),
    .mode_or_i(mode_or_i), .veto_i(veto_i), .veto_en_i(veto_en_i),
    .width_i(width_i), .out_inv_i(out_inv_i), .trig_o(trig_o));

  // {en[3:0], or, hit[3:0], veto[1:0], veto_en[1:0], expected}
  localparam int NV = 12;
  localparam logic [13:0] VEC [NV] = '{
    {4'hF,1'b0,4'hF,2'b00,2'b00,1'b1},   // R2 all hit
    {4'hF,1'b0,4'h7,2'b00,2'b00,1'b0},   // R2 one missing
    {4'h7,1'b0,4'h7,2'b00,2'b00,1'b1},   // R2 disabled counts hit
    {4'hF,1'b1,4'h1,2'b00,2'b00,1'b1},   // R3 one hit
    {4'hF,1'b1,4'h0,2'b00,2'b00,1'b0},   // R3 none
    {4'h0,1'b0,4'hF,2'b00,2'b00,1'b0},   // R4 AND
    {4'h0,1'b1,4'hF,2'b00,2'b00,1'b0},   // R4 OR
    {4'hE,1'b1,4'h1,2'b00,2'b00,1'b0},   // R3 disabled excluded
    {4'hF,1'b1,4'hF,2'b01,2'b01,1'b0},   // R5 veto 0
    {4'hF,1'b1,4'hF,2'b01,2'b10,1'b1},   // R5 switch off
    {4'hF,1'b1,4'hF,2'b10,2'b10,1'b0},   // R5 veto 1
    {4'hF,1'b0,4'hF,2'b11,2'b00,1'b1}    // R5 both switched off
  };

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic pulse_once();
    @(negedge clk); hit_i = 4'hF;
    @(negedge clk); hit_i = '0;
  endtask

  task automatic count_width(input logic [3:0] w, input int exp, input string req);
    int n = 0;
    width_i = w; in_en_i = 4'hF; mode_or_i = 1'b0; out_inv_i = '0;
    pulse_once();
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (trig_o[0]) n++;
    end
    check(req, 3'(n), 3'(exp));
    if (exp > 7) check(req, 3'(n >> 3), 3'(exp >> 3));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", trig_o, 3'b000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", trig_o, 3'b000);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {in_en_i, mode_or_i, hit_i, veto_i, veto_en_i} = VEC[i][13:1];
      @(negedge clk);            // E0 has sampled
      hit_i = '0; veto_i = '0;
      @(negedge clk);            // after E1 (R9)
      check($sformatf("R2/R3/R4/R5/R9 vec %0d", i), {2'b00, trig_o[0]}, {2'b00, VEC[i][0]});
      repeat (2) @(negedge clk);
    end

    count_width(4'd5, 5, "R6 width 5");
    count_width(4'd15, 15, "R6 width 15");
    count_width(4'd0, 1, "R6 width 0");

    // R7: hits held, pattern W high then 1 low
    width_i = 4'd4; in_en_i = 4'hF; mode_or_i = 1'b0;
    @(negedge clk); hit_i = 4'hF;
    @(negedge clk);
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      check($sformatf("R7 cycle %0d", k), {2'b00, trig_o[0]}, {2'b00, (k % 5) != 4});
    end
    hit_i = '0;
    repeat (8) @(negedge clk);

    // R8: inverted outputs idle high, pulse low
    out_inv_i = 3'b101; width_i = 4'd2;
    @(negedge clk);
    check("R8 idle", trig_o, 3'b101);
    pulse_once();
    @(negedge clk);
    check("R8 active", trig_o, 3'b010);
    repeat (3) @(negedge clk);
    check("R8 back idle", trig_o, 3'b101);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule